// File: doc/BRIEF.md
# Program Sequencer with Return-Address Stack

This block holds the program counter of a small microcontroller and decides, once per instruction step, which address is fetched next. Decode supplies a flow command, a condition code, a 12-bit target address and the carry and zero flags from the ALU. The block advances the counter, branches, or enters and leaves subroutines through a hardware stack of return addresses.

A subroutine entry saves the address of the calling instruction itself. A return therefore resumes one past the saved address. Calls and returns are conditional in the same way as jumps. When the condition fails, execution falls through to the next address. A stub interrupt-enable bit is kept here: it is set and cleared by its own commands and written by the return-from-interrupt command. Stack misuse is never allowed to corrupt the stack. A call into a full stack and a return from an empty one each latch their own error flag, and the program counter simply moves to the next address.

Top module: `prog_seq`

## Requirements
- R1: While rst_ni is low and after its release, pc_o is 0x000, ie_o is 0, ovf_o and unf_o are 0, and the stack is empty.
- R2: When step_i is low, pc_o, ie_o and the stack hold whatever cmd_i carries. With step_i high and cmd_i 0 (none) or 7 (unused), pc_o advances by one and wraps from 0xFFF to 0x000.
- R3: cond_i encoding: 0 always, 1 carry set, 2 carry clear, 3 zero set, 4 zero clear. Codes 5 to 7 are never satisfied.
- R4: A jump (cmd_i 1) whose condition holds loads target_i into pc_o on the step edge. Otherwise pc_o advances by one.
- R5: A call (cmd_i 2) whose condition holds pushes the current pc_o and loads target_i. Otherwise pc_o advances by one and the stack is untouched.
- R6: A return (cmd_i 3) whose condition holds pops the top entry and loads it plus one. Otherwise pc_o advances by one and the stack is untouched.
- R7: Returns resume in last-in, first-out order across nested calls, up to a stack of 30 entries.
- R8: A return-from-interrupt (cmd_i 4) ignores cond_i, returns as in R6, and loads ie_o from ie_flag_i.
- R9: cmd_i 5 sets ie_o and cmd_i 6 clears it. Both advance pc_o by one.
- R10: A taken call while 30 entries are held sets ovf_o, advances pc_o by one, and leaves all stack entries intact.
- R11: A taken return or return-from-interrupt with an empty stack sets unf_o and advances pc_o by one.
- R12: ovf_o and unf_o stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Instruction step enable |
| cmd_i | input | 3 | Flow command |
| cond_i | input | 3 | Condition code |
| target_i | input | 12 | Branch or call target |
| carry_i | input | 1 | Carry flag |
| zero_i | input | 1 | Zero flag |
| ie_flag_i | input | 1 | Interrupt-enable value for return-from-interrupt |
| pc_o | output | 12 | Program counter (next fetch address) |
| ie_o | output | 1 | Interrupt-enable bit |
| ovf_o | output | 1 | Sticky stack overflow |
| unf_o | output | 1 | Sticky stack underflow |

## Verification
Each condition code is tried with its flag both satisfying and failing it. The landing address then shows whether the target or the next address was taken, which separates polarity errors from errors in selecting the flag. Calls are nested and unwound with returns whose flags block some of them. That exposes a wrong pop order, an off-by-one on the resume address, and a stack that moves on a skipped command. Filling the stack to its limit and popping past empty checks that an overflowing call leaves every saved address in place. The same sequence shows that both error flags persist until reset.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    FC_NONE   = 3'd0,
    FC_JUMP   = 3'd1,
    FC_CALL   = 3'd2,
    FC_RET    = 3'd3,
    FC_RETI   = 3'd4,
    FC_IE_SET = 3'd5,
    FC_IE_CLR = 3'd6
  } flow_cmd_e;

  typedef enum logic [2:0] {
    CC_ALWAYS = 3'd0,
    CC_C      = 3'd1,
    CC_NC     = 3'd2,
    CC_Z      = 3'd3,
    CC_NZ     = 3'd4
  } cond_e;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import seq_pkg::*;
(
  input  logic [2:0] cond_i,
  input  logic       carry_i,
  input  logic       zero_i,
  output logic       taken_o
);
  always_comb begin
    case (cond_i)
      CC_ALWAYS: taken_o = 1'b1;
      CC_C:      taken_o = carry_i;
      CC_NC:     taken_o = ~carry_i;
      CC_Z:      taken_o = zero_i;
      CC_NZ:     taken_o = ~zero_i;
      default:   taken_o = 1'b0;  // reserved codes never satisfied
    endcase
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int unsigned DEPTH = 30,
  parameter int unsigned W     = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] top_idx;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign top_idx = IW'(cnt_q - CW'(1));
  assign top_o   = empty_o ? '0 : mem[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (push_i) cnt_q <= cnt_q + CW'(1);
    else if (pop_i)  cnt_q <= cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[IW'(cnt_q)] <= wdata_i;
  end

  a_r10_push_not_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r11_pop_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r7_push_pop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import seq_pkg::*;
#(
  parameter int unsigned PC_W      = 12,
  parameter int unsigned STK_DEPTH = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic [2:0]      cmd_i,
  input  logic [2:0]      cond_i,
  input  logic [PC_W-1:0] target_i,
  input  logic            carry_i,
  input  logic            zero_i,
  input  logic            ie_flag_i,
  output logic [PC_W-1:0] pc_o,
  output logic            ie_o,
  output logic            ovf_o,
  output logic            unf_o
);
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, stk_top;
  logic taken, stk_full, stk_empty;
  logic do_jump, do_call, do_ret, push, pop;

  cond_eval u_cond (
    .cond_i  (cond_i),
    .carry_i (carry_i),
    .zero_i  (zero_i),
    .taken_o (taken)
  );

  ret_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (pc_q),
    .top_o   (stk_top),
    .full_o  (stk_full),
    .empty_o (stk_empty)
  );

  assign pc_inc  = pc_q + PC_W'(1);
  assign do_jump = step_i && (cmd_i == FC_JUMP) && taken;
  assign do_call = step_i && (cmd_i == FC_CALL) && taken;
  // return-from-interrupt is unconditional
  assign do_ret  = step_i && (((cmd_i == FC_RET) && taken) || (cmd_i == FC_RETI));
  assign push    = do_call && !stk_full;
  assign pop     = do_ret && !stk_empty;

  always_comb begin
    if (push)         pc_d = target_i;
    else if (pop)     pc_d = stk_top + PC_W'(1);
    else if (do_jump) pc_d = target_i;
    else if (step_i)  pc_d = pc_inc;
    else              pc_d = pc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ie_o  <= 1'b0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (do_call && stk_full)  ovf_o <= 1'b1;
      if (do_ret && stk_empty)  unf_o <= 1'b1;
      if (step_i) begin
        if (cmd_i == FC_IE_SET)      ie_o <= 1'b1;
        else if (cmd_i == FC_IE_CLR) ie_o <= 1'b0;
        else if (cmd_i == FC_RETI)   ie_o <= ie_flag_i;
      end
    end
  end

  assign pc_o = pc_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o) && $stable(ie_o));
  a_r4_jump_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cmd_i == FC_JUMP && taken) |=> pc_o == $past(target_i));
  a_r5_call_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cmd_i == FC_CALL && taken && !stk_full) |=> pc_o == $past(target_i));
  a_r9_ie_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cmd_i == FC_IE_SET) |=> ie_o);
  a_r12_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  a_r12_unf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);
endmodule

// File: tb/tb_prog_seq.sv
module tb_prog_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [2:0]  cmd = 3'd0, cond = 3'd0;
  logic [11:0] tgt = 12'h000;
  logic        c = 1'b0, z = 1'b0, ief = 1'b0;
  logic [11:0] pc;
  logic        ie, ovf, unf;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  prog_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .cmd_i(cmd), .cond_i(cond),
    .target_i(tgt), .carry_i(c), .zero_i(z), .ie_flag_i(ief),
    .pc_o(pc), .ie_o(ie), .ovf_o(ovf), .unf_o(unf)
  );

  // {cmd, cond, target, carry, zero, expected pc}
  localparam logic [31:0] VEC [18] = '{
    {3'd0, 3'd0, 12'h000, 1'b0, 1'b0, 12'h001},  // R2 none
    {3'd1, 3'd0, 12'h100, 1'b0, 1'b0, 12'h100},  // R4 always
    {3'd1, 3'd1, 12'h700, 1'b0, 1'b0, 12'h101},  // R3 C fails
    {3'd1, 3'd1, 12'h200, 1'b1, 1'b0, 12'h200},  // R3 C holds
    {3'd1, 3'd2, 12'h300, 1'b1, 1'b0, 12'h201},  // R3 NC fails
    {3'd1, 3'd2, 12'h300, 1'b0, 1'b0, 12'h300},  // R3 NC holds
    {3'd1, 3'd3, 12'h400, 1'b0, 1'b0, 12'h301},  // R3 Z fails
    {3'd1, 3'd3, 12'h400, 1'b0, 1'b1, 12'h400},  // R3 Z holds
    {3'd1, 3'd4, 12'h500, 1'b0, 1'b1, 12'h401},  // R3 NZ fails
    {3'd1, 3'd4, 12'h500, 1'b0, 1'b0, 12'h500},  // R3 NZ holds
    {3'd2, 3'd0, 12'h600, 1'b0, 1'b0, 12'h600},  // R5 call, push 500
    {3'd2, 3'd3, 12'h700, 1'b0, 1'b0, 12'h601},  // R5 call skipped
    {3'd2, 3'd1, 12'h700, 1'b1, 1'b0, 12'h700},  // R5 call, push 601
    {3'd3, 3'd2, 12'h000, 1'b1, 1'b0, 12'h701},  // R6 return skipped
    {3'd3, 3'd0, 12'h000, 1'b0, 1'b0, 12'h602},  // R7 pops 601
    {3'd3, 3'd3, 12'h000, 1'b0, 1'b1, 12'h501},  // R7 pops 500
    {3'd1, 3'd5, 12'h123, 1'b1, 1'b1, 12'h502},  // R3 reserved code
    {3'd7, 3'd0, 12'h123, 1'b0, 1'b0, 12'h503}   // R2 unused cmd
  };

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_step(input logic [2:0] k, input logic [2:0] cc, input logic [11:0] t,
                         input logic cy, input logic zr, input logic f);
    @(negedge clk);
    step = 1'b1; cmd = k; cond = cc; tgt = t; c = cy; z = zr; ief = f;
    @(posedge clk);
    #1;
    @(negedge clk);
    step = 1'b0; cmd = 3'd0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] pushed [30];
    do_reset();
    #1;
    chk("R1 pc", pc, 12'h000);
    chk("R1 ie", {11'd0, ie}, 12'h000);
    chk("R1 ovf", {11'd0, ovf}, 12'h000);
    chk("R1 unf", {11'd0, unf}, 12'h000);

    for (int i = 0; i < 18; i++) begin
      do_step(VEC[i][31:29], VEC[i][28:26], VEC[i][25:14], VEC[i][13], VEC[i][12], 1'b0);
      chk($sformatf("R3-R7 vector %0d", i), pc, VEC[i][11:0]);
    end
    chk("R11 no underflow yet", {11'd0, unf}, 12'h000);

    // R2 step low holds even with a jump command
    @(negedge clk);
    step = 1'b0; cmd = 3'd1; cond = 3'd0; tgt = 12'hABC;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 hold", pc, 12'h503);
    cmd = 3'd0;

    // R2 wrap
    do_step(3'd1, 3'd0, 12'hFFF, 1'b0, 1'b0, 1'b0);
    do_step(3'd0, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0);
    chk("R2 wrap", pc, 12'h000);

    // R9 interrupt enable commands
    do_step(3'd5, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0);
    chk("R9 ie set", {11'd0, ie}, 12'h001);
    chk("R9 pc", pc, 12'h001);
    do_step(3'd6, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0);
    chk("R9 ie clear", {11'd0, ie}, 12'h000);

    // R8 return-from-interrupt, reserved cond ignored
    do_step(3'd2, 3'd0, 12'h050, 1'b0, 1'b0, 1'b0);   // push 002
    do_step(3'd4, 3'd6, 12'h000, 1'b0, 1'b0, 1'b1);
    chk("R8 pc", pc, 12'h003);
    chk("R8 ie", {11'd0, ie}, 12'h001);
    chk("R8 no unf", {11'd0, unf}, 12'h000);
    // R11 reti on empty stack
    do_step(3'd4, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0);
    chk("R11 reti empty pc", pc, 12'h004);
    chk("R11 unf", {11'd0, unf}, 12'h001);
    chk("R8 ie from flag", {11'd0, ie}, 12'h000);
    do_step(3'd0, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0);
    chk("R12 unf sticky", {11'd0, unf}, 12'h001);

    // R10 overflow
    do_reset();
    #1;
    chk("R1 unf cleared", {11'd0, unf}, 12'h000);
    for (int k = 0; k < 30; k++) begin
      pushed[k] = (k == 0) ? 12'h000 : 12'h00F + 12'(k);
      do_step(3'd2, 3'd0, 12'h010 + 12'(k), 1'b0, 1'b0, 1'b0);
    end
    chk("R7 depth 30 no ovf", {11'd0, ovf}, 12'h000);
    do_step(3'd2, 3'd0, 12'hABC, 1'b0, 1'b0, 1'b0);
    chk("R10 ovf", {11'd0, ovf}, 12'h001);
    chk("R10 pc", pc, 12'h02E);
    for (int j = 0; j < 30; j++) begin
      do_step(3'd3, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0);
      chk($sformatf("R10 R7 unwind %0d", j), pc, pushed[29 - j] + 12'h001);
    end
    chk("R12 ovf sticky", {11'd0, ovf}, 12'h001);
    do_step(3'd3, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0);
    chk("R11 return empty pc", pc, 12'h002);
    chk("R11 unf", {11'd0, unf}, 12'h001);

    do_reset();
    #1;
    chk("R1 ovf cleared", {11'd0, ovf}, 12'h000);
    chk("R1 pc after reset", pc, 12'h000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule